// File: doc/BRIEF.md
# Chiplet Control Register Bank

A bank of 64-bit storage registers behind a single-cycle register port that carries an address, a write enable, a read enable, write data and read data. The port carries byte addresses. Every access is a full 64-bit word, so the register index is the address shifted right by three and the three low address bits are ignored. The index space holds 1024 entries.

There are eight aliased registers: six control words and two configuration words. Each one is reached through three windows. The direct window replaces the value. The set window ORs the write data in. The clear window removes the bits where the write data is one. The set and clear windows cannot be read, and a read of either returns all ones. Four more words are plain read/write registers: status, mask, protect mode and atomic lock. The block stores values only and drives nothing from them.

Any access that the map cannot serve raises a one-cycle error pulse. That covers an unmapped index and a read of a set or clear window. Such a read returns all ones. A write to an unmapped index changes nothing.

Top module: `chiplet_ctrl_bank`

## Requirements
- R1: While rst_ni is low, and after it is released, every register is zero and rdata_o and err_o are zero.
- R2: A write to index 0x00..0x05 replaces control register n (n = index) with wdata_i.
- R3: A write to index 0x10+n (n 0..5) sets control register n to its old value OR wdata_i.
- R4: A write to index 0x20+n (n 0..5) sets control register n to its old value AND NOT wdata_i.
- R5: Configuration register 0 uses indices 0x08 (replace), 0x18 (OR) and 0x28 (AND NOT). Configuration register 1 uses 0x09, 0x19 and 0x29 in the same way.
- R6: Status at index 0x100, mask at 0x101, protect mode at 0x3FE and atomic lock at 0x3FF are plain registers: a write replaces the value and a read returns it.
- R7: A read of any set or clear window returns 0xFFFF_FFFF_FFFF_FFFF, changes no register and raises err_o for one cycle.
- R8: A read of an unmapped index returns all ones and raises err_o. A write to an unmapped index changes no register and raises err_o.
- R9: A write takes effect at the clock edge where we_i is sampled high. rdata_o is updated at the edge where re_i is sampled high and keeps its value otherwise. When read and write hit the same cycle, the read returns the value from before the write.
- R10: The register index is addr_i[12:3]. Bits addr_i[2:0] do not affect which register is reached.
- R11: err_o is high only in the cycle after an access that R7 or R8 names. It stays low after idle cycles and after legal accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Byte address |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| err_o | output | 1 | One-cycle pulse for an illegal or unmapped access |

## Verification
Registers have no path to the ports except through a read, so a corrupted register stays hidden until its direct window is read, and then shows on rdata_o one cycle later. The bench therefore follows every write phase with reads of every mapped direct index, and it interleaves random mixed traffic with reads. A decode fault that sends an alias or an unmapped access to the wrong place shows on the next cycle, either as a missing or extra err_o pulse or as read data other than all ones. It can also show later, as a register whose value has drifted from the reference model.

// File: rtl/cplt_bank_pkg.sv
package cplt_bank_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DIRECT,
    ACC_SET,
    ACC_CLR,
    ACC_PLAIN
  } acc_kind_e;

  localparam int unsigned N_CTRL  = 6;
  localparam int unsigned N_CFG   = 2;
  localparam int unsigned CFG_OFF = 8;
  localparam int unsigned N_PLAIN = 4;
  localparam int unsigned STAT_IDX = 'h100;
  localparam int unsigned MASK_IDX = 'h101;
endpackage

// File: rtl/cplt_bank_decode.sv
module cplt_bank_decode
  import cplt_bank_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned N_ALIAS = N_CTRL + N_CFG,
  localparam int unsigned SLOT_W = $clog2(N_ALIAS),
  localparam int unsigned PSEL_W = $clog2(N_PLAIN)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output acc_kind_e         kind_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [PSEL_W-1:0] psel_o
);
  localparam int unsigned LOCK_IDX = (1 << IDX_W) - 1;
  localparam int unsigned PROT_IDX = (1 << IDX_W) - 2;

  logic        hit;
  int unsigned off;

  always_comb begin
    kind_o = ACC_NONE;
    slot_o = '0;
    psel_o = '0;
    hit    = 1'b0;
    off    = int'(idx_i[3:0]);
    // windows 0..2 live in the lowest 48 indices
    if (idx_i[IDX_W-1:6] == '0 && idx_i[5:4] != 2'b11) begin
      if (off < N_CTRL) begin
        hit    = 1'b1;
        slot_o = SLOT_W'(off);
      end else if (off >= CFG_OFF && off < CFG_OFF + N_CFG) begin
        hit    = 1'b1;
        slot_o = SLOT_W'(off - CFG_OFF + N_CTRL);
      end
      if (hit) begin
        unique case (idx_i[5:4])
          2'b00:   kind_o = ACC_DIRECT;
          2'b01:   kind_o = ACC_SET;
          default: kind_o = ACC_CLR;
        endcase
      end
    end else if (idx_i == IDX_W'(STAT_IDX)) begin
      kind_o = ACC_PLAIN;
      psel_o = PSEL_W'(0);
    end else if (idx_i == IDX_W'(MASK_IDX)) begin
      kind_o = ACC_PLAIN;
      psel_o = PSEL_W'(1);
    end else if (idx_i == IDX_W'(PROT_IDX)) begin
      kind_o = ACC_PLAIN;
      psel_o = PSEL_W'(2);
    end else if (idx_i == IDX_W'(LOCK_IDX)) begin
      kind_o = ACC_PLAIN;
      psel_o = PSEL_W'(3);
    end
  end
endmodule

// File: rtl/cplt_alias_reg.sv
module cplt_alias_reg
  import cplt_bank_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  acc_kind_e     kind_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (wr_i) begin
      unique case (kind_i)
        ACC_DIRECT: nxt = wdata_i;
        ACC_SET:    nxt = q_o | wdata_i;
        ACC_CLR:    nxt = q_o & ~wdata_i;
        default:    nxt = q_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/chiplet_ctrl_bank.sv
module chiplet_ctrl_bank
  import cplt_bank_pkg::*;
#(
  parameter int unsigned DW    = 64,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned ADDR_W = IDX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o
);
  localparam int unsigned N_ALIAS = N_CTRL + N_CFG;
  localparam int unsigned SLOT_W  = $clog2(N_ALIAS);
  localparam int unsigned PSEL_W  = $clog2(N_PLAIN);

  logic [IDX_W-1:0]  idx;
  acc_kind_e         acc_kind;
  logic [SLOT_W-1:0] acc_slot;
  logic [PSEL_W-1:0] acc_psel;
  logic [DW-1:0]     alias_q [N_ALIAS];
  logic [DW-1:0]     plain_q [N_PLAIN];
  logic [DW-1:0]     rd_val;
  logic              acc_err;
  logic              unused_lsb;

  assign idx        = addr_i[ADDR_W-1:3];
  assign unused_lsb = ^addr_i[2:0];

  cplt_bank_decode #(
    .IDX_W  (IDX_W),
    .N_ALIAS(N_ALIAS)
  ) u_dec (
    .idx_i (idx),
    .kind_o(acc_kind),
    .slot_o(acc_slot),
    .psel_o(acc_psel)
  );

  for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
    cplt_alias_reg #(.DW(DW)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && acc_slot == SLOT_W'(g)),
      .kind_i (acc_kind),
      .wdata_i(wdata_i),
      .q_o    (alias_q[g])
    );
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) plain_q[g] <= '0;
      else if (we_i && acc_kind == ACC_PLAIN && acc_psel == PSEL_W'(g))
        plain_q[g] <= wdata_i;
    end
  end

  always_comb begin
    unique case (acc_kind)
      ACC_DIRECT: rd_val = alias_q[acc_slot];
      ACC_PLAIN:  rd_val = plain_q[acc_psel];
      default:    rd_val = '1;
    endcase
  end

  assign acc_err = (acc_kind == ACC_NONE && (re_i || we_i))
                || (re_i && (acc_kind == ACC_SET || acc_kind == ACC_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (re_i) rdata_o <= rd_val;
      err_o <= acc_err;
    end
  end
endmodule

// File: rtl/cplt_bank_chk.sv
module cplt_bank_chk
  import cplt_bank_pkg::*;
#(
  parameter int unsigned DW      = 64,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned N_ALIAS = 8,
  localparam int unsigned SLOT_W = $clog2(N_ALIAS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              err_o,
  input acc_kind_e         acc_kind,
  input logic [SLOT_W-1:0] acc_slot,
  input logic [DW-1:0]     alias_q [N_ALIAS]
);
  logic [SLOT_W-1:0] slot_d;
  logic [DW-1:0]     wdata_d;
  logic [DW-1:0]     old_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_d  <= '0;
      wdata_d <= '0;
      old_d   <= '0;
    end else begin
      slot_d  <= acc_slot;
      wdata_d <= wdata_i;
      old_d   <= alias_q[acc_slot];
    end
  end

  // R2
  direct_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && acc_kind == ACC_DIRECT) |=> alias_q[slot_d] == wdata_d);

  // R3
  set_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && acc_kind == ACC_SET) |=> alias_q[slot_d] == (old_d | wdata_d));

  // R4
  clr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && acc_kind == ACC_CLR) |=> alias_q[slot_d] == (old_d & ~wdata_d));

  // R7
  alias_rd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (acc_kind == ACC_SET || acc_kind == ACC_CLR)) |=> (rdata_o == '1 && err_o));

  // R8
  unmapped_rd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && acc_kind == ACC_NONE) |=> (rdata_o == '1 && err_o));

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  // R11
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!re_i && !we_i) |=> !err_o);
endmodule

bind chiplet_ctrl_bank cplt_bank_chk #(
  .DW     (DW),
  .IDX_W  (IDX_W),
  .N_ALIAS(N_ALIAS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .re_i    (re_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .acc_kind(acc_kind),
  .acc_slot(acc_slot),
  .alias_q (alias_q)
);

// File: tb/chiplet_ctrl_bank_test.sv
module chiplet_ctrl_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        err;

  int chk_cnt = 0;
  int fail_cnt = 0;
  bit finished = 1'b0;

  // reference model
  logic [63:0] m_ctrl [6];
  logic [63:0] m_cfg  [2];
  logic [63:0] m_pln  [4];
  logic [63:0] exp_rdata = '0;
  logic        exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chiplet_ctrl_bank uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .we_i   (we),
    .re_i   (re),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .err_o  (err)
  );

  // grp: 0 unmapped, 1 control, 2 configuration, 3 plain; op: 0 replace, 1 or, 2 and-not
  function automatic void m_decode(input int idx, output int grp, output int n, output int op);
    grp = 0; n = 0; op = 0;
    if (idx < 'h30) begin
      op = idx / 16;
      n  = idx % 16;
      if (n < 6) grp = 1;
      else if (n == 8 || n == 9) begin grp = 2; n = n - 8; end
    end else if (idx == 'h100) begin grp = 3; n = 0; end
    else if (idx == 'h101) begin grp = 3; n = 1; end
    else if (idx == 'h3FE) begin grp = 3; n = 2; end
    else if (idx == 'h3FF) begin grp = 3; n = 3; end
  endfunction

  function automatic logic [63:0] m_apply(input logic [63:0] old, input logic [63:0] d, input int op);
    if (op == 0) return d;
    if (op == 1) return old | d;
    return old & ~d;
  endfunction

  task automatic check(input string tag);
    chk_cnt++;
    if (rdata !== exp_rdata) begin
      fail_cnt++;
      $display("FAIL %s rdata_o actual=%h expected=%h", tag, rdata, exp_rdata);
    end
    chk_cnt++;
    if (err !== exp_err) begin
      fail_cnt++;
      $display("FAIL %s err_o actual=%b expected=%b", tag, err, exp_err);
    end
  endtask

  // one bus cycle; called and returning at a negative edge
  task automatic access(input bit r, input bit w, input int idx, input logic [2:0] lsb,
                        input logic [63:0] d, input string tag);
    int grp, n, op;
    logic [63:0] cur;
    m_decode(idx, grp, n, op);
    addr = {idx[9:0], lsb}; re = r; we = w; wdata = d;
    cur = ONES;
    if (grp == 1 && op == 0) cur = m_ctrl[n];
    if (grp == 2 && op == 0) cur = m_cfg[n];
    if (grp == 3) cur = m_pln[n];
    if (r) exp_rdata = cur;
    exp_err = ((r || w) && grp == 0) || (r && grp != 0 && grp != 3 && op != 0);
    if (w) begin
      if (grp == 1) m_ctrl[n] = m_apply(m_ctrl[n], d, op);
      if (grp == 2) m_cfg[n]  = m_apply(m_cfg[n], d, op);
      if (grp == 3) m_pln[n]  = d;
    end
    @(posedge clk);
    @(negedge clk);
    re = 1'b0; we = 1'b0;
    check(tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 6; i++) access(1, 0, i, 3'd0, '0, tag);
    access(1, 0, 'h08, 3'd0, '0, tag);
    access(1, 0, 'h09, 3'd0, '0, tag);
    access(1, 0, 'h100, 3'd0, '0, tag);
    access(1, 0, 'h101, 3'd0, '0, tag);
    access(1, 0, 'h3FE, 3'd0, '0, tag);
    access(1, 0, 'h3FF, 3'd0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fail_cnt++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    int mapped [12] = '{'h00, 'h03, 'h05, 'h08, 'h09, 'h13, 'h19, 'h22, 'h28, 'h100, 'h3FE, 'h3FF};
    for (int i = 0; i < 6; i++) m_ctrl[i] = '0;
    for (int i = 0; i < 2; i++) m_cfg[i] = '0;
    for (int i = 0; i < 4; i++) m_pln[i] = '0;

    // R1 during reset
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    read_all("R1");

    // R2 replace control registers
    for (int i = 0; i < 6; i++) access(0, 1, i, 3'd0, 64'h1111_0000_0000_0001 * (i + 1), "R2");
    access(0, 1, 2, 3'd0, 64'hDEAD_BEEF_0BAD_F00D, "R2");
    read_all("R2");

    // R3 set windows
    for (int i = 0; i < 6; i++) access(0, 1, 'h10 + i, 3'd0, 64'h8000_0000_0000_0100 >> i, "R3");
    read_all("R3");

    // R4 clear windows
    for (int i = 0; i < 6; i++) access(0, 1, 'h20 + i, 3'd0, 64'h0000_FFFF_0000_000F << i, "R4");
    read_all("R4");

    // R5 configuration registers
    access(0, 1, 'h08, 3'd0, 64'h0F0F_0F0F_0F0F_0F0F, "R5");
    access(0, 1, 'h09, 3'd0, 64'h1234_5678_9ABC_DEF0, "R5");
    access(0, 1, 'h18, 3'd0, 64'hF000_0000_0000_0000, "R5");
    access(0, 1, 'h29, 3'd0, 64'h0000_0000_0000_00F0, "R5");
    access(1, 0, 'h08, 3'd0, '0, "R5");
    access(1, 0, 'h09, 3'd0, '0, "R5");
    access(0, 1, 'h28, 3'd0, 64'h0F00_0000_0000_000F, "R5");
    access(0, 1, 'h19, 3'd0, 64'h0000_0000_0000_0001, "R5");
    access(1, 0, 'h08, 3'd0, '0, "R5");
    access(1, 0, 'h09, 3'd0, '0, "R5");

    // R6 plain registers
    access(0, 1, 'h100, 3'd0, 64'hAAAA_5555_AAAA_5555, "R6");
    access(0, 1, 'h101, 3'd0, 64'h0000_0000_FFFF_0000, "R6");
    access(0, 1, 'h3FE, 3'd0, 64'h8000_0000_0000_0001, "R6");
    access(0, 1, 'h3FF, 3'd0, ONES, "R6");
    read_all("R6");

    // R7 alias reads
    for (int i = 0; i < 6; i++) access(1, 0, 'h10 + i, 3'd0, '0, "R7");
    access(1, 0, 'h28, 3'd0, '0, "R7");
    access(1, 0, 'h19, 3'd0, '0, "R7");
    access(1, 0, 'h25, 3'd0, '0, "R7");
    read_all("R7");

    // R8 unmapped accesses
    access(1, 0, 'h06, 3'd0, '0, "R8");
    access(1, 0, 'h0A, 3'd0, '0, "R8");
    access(0, 1, 'h07, 3'd0, ONES, "R8");
    access(0, 1, 'h16, 3'd0, ONES, "R8");
    access(0, 1, 'h30, 3'd0, ONES, "R8");
    access(0, 1, 'h40, 3'd0, ONES, "R8");
    access(0, 1, 'h102, 3'd0, ONES, "R8");
    access(0, 1, 'h3FD, 3'd0, ONES, "R8");
    access(0, 1, 'h200, 3'd0, ONES, "R8");
    access(1, 0, 'h3FD, 3'd0, '0, "R8");
    read_all("R8");

    // R9 timing: write then immediate read, combined access, hold
    access(0, 1, 1, 3'd0, 64'h0123_4567_89AB_CDEF, "R9");
    access(1, 0, 1, 3'd0, '0, "R9");
    access(1, 1, 1, 3'd0, 64'hFEDC_BA98_7654_3210, "R9");
    access(0, 0, 1, 3'd0, '0, "R9");
    access(0, 1, 1, 3'd0, '0, "R9");
    access(1, 1, 'h101, 3'd0, 64'h5A5A, "R9");
    access(1, 0, 1, 3'd0, '0, "R9");
    access(1, 0, 'h101, 3'd0, '0, "R9");

    // R10 low address bits ignored
    access(0, 1, 4, 3'd7, 64'hCAFE_0000_0000_BABE, "R10");
    access(1, 0, 4, 3'd3, '0, "R10");
    access(0, 1, 'h3FF, 3'd5, 64'h77, "R10");
    access(1, 0, 'h3FF, 3'd1, '0, "R10");

    // R11 quiet after idle and legal traffic
    access(0, 0, 'h06, 3'd0, '0, "R11");
    access(0, 1, 'h13, 3'd0, 64'h3, "R11");
    access(0, 0, 'h06, 3'd0, '0, "R11");

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 13);
      int idx = (sel < 12) ? mapped[sel] : ((sel == 12) ? 'h0B : int'($urandom_range(0, 'h3FF)));
      bit r = 1'($urandom_range(0, 1));
      bit w = 1'($urandom_range(0, 1));
      logic [63:0] d = {$urandom, $urandom};
      access(r, w, idx, 3'($urandom_range(0, 7)), d, "R9");
    end
    read_all("R9");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule